// File: doc/BRIEF.md
# Wide Store Mask Classifier

This block watches write and read requests on a 256-bit data-memory port and decides, one cycle later, what kind of access each request was. A write is judged from its bit-granular write mask. When every mask bit is set, the access is a full-width store. When the mask covers exactly one 32-bit lane, fully and with no other bit set, the access is a narrow store. Every other mask is a malformed store.

Each kind produces its own report. A full-width store reports the 256-bit-aligned address and all of its data. A narrow store reports the byte address of the lane it wrote and only that lane's 32 bits. A malformed store raises an error flag and passes on the whole mask and the whole data word. A read is always reported as a full 256-bit value at the aligned address, however much of it the consuming instruction needs.

The block sits beside a memory port as a passive observer. Its registered results can drive a trace formatter or a checker. It neither stores data nor formats text.

Top module: `wide_store_classifier`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, `out_valid`, `out_err`, `out_kind`, `out_addr`, `out_data` and `out_mask` are all zero.
- R2: `out_valid` is high in exactly the cycles that follow a cycle with `req_valid` high, so each result lasts one cycle.
- R3: A request with `req_write` low reports kind 0 (load), the address with its low 5 bits cleared, the full `req_data`, and a zero `out_mask`. The mask is ignored.
- R4: A write whose 256 mask bits are all set reports kind 1 (wide store), the 32-byte-aligned address, the full data, and a zero `out_mask`.
- R5: Lane k is data and mask bits [32k+31:32k], so lane 0 is bits 31:0 at the lowest address. A write whose mask has lane k all ones and every other bit zero reports kind 2 (narrow store). Its address is the aligned address plus 4·k. Its `out_data` holds lane k of the data in bits 31:0 and zeros above, and its `out_mask` is zero.
- R6: Any other write mask reports kind 3 (error), the aligned address, the full data and the full mask. This includes an all-zero mask, a partly set lane, several lanes, and one full lane plus a stray bit.
- R7: `out_err` is high exactly when `out_valid` is high and `out_kind` is 3.
- R8: In a cycle that follows no request, `out_kind`, `out_addr`, `out_data`, `out_mask` and `out_err` are all zero.
- R9: The low 5 bits of `req_addr` have no effect on any reported address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | A request is present this cycle |
| req_write | input | 1 | 1 = store, 0 = load |
| req_addr | input | 32 | Byte address of the request |
| req_data | input | 256 | Store data, or the returned load value |
| req_mask | input | 256 | Bit-level write mask |
| out_valid | output | 1 | Result present this cycle |
| out_kind | output | 2 | 0 load, 1 wide store, 2 narrow store, 3 error |
| out_addr | output | 32 | Reported address |
| out_data | output | 256 | Reported data |
| out_mask | output | 256 | Full mask on error, else zero |
| out_err | output | 1 | Malformed store flag |

## Verification
The full-width test and the single-lane test look at the same mask in the same cycle. Masks that sit between them must resolve to exactly one kind. These masks are one full lane plus a stray bit, two full lanes, seven full lanes, and all lanes but one bit. The other case that falls in one cycle is a result being presented while a different kind of request is being captured. Back-to-back requests of alternating kinds with no idle gap provoke it. A behavioural model in the bench, built on loops over mask bits, predicts every output in every cycle and compares it field by field.

// File: rtl/wsc_pkg.sv
package wsc_pkg;

    localparam int WSC_ADDR_W = 32;
    localparam int WSC_DATA_W = 256;
    localparam int WSC_LANE_W = 32;

    typedef enum logic [1:0] {
        KIND_LOAD   = 2'd0,
        KIND_WIDE   = 2'd1,
        KIND_NARROW = 2'd2,
        KIND_ERR    = 2'd3
    } store_kind_e;

    typedef struct packed {
        store_kind_e kind;
        logic        fault;
    } class_t;

    function automatic int idx_width(input int lanes);
        return (lanes > 1) ? $clog2(lanes) : 1;
    endfunction

endpackage

// File: rtl/wsc_lane_scan.sv
module wsc_lane_scan
    import wsc_pkg::*;
#(
    parameter int DATA_W = WSC_DATA_W,
    parameter int LANE_W = WSC_LANE_W,
    localparam int NLANES = DATA_W / LANE_W
) (
    input  logic [DATA_W-1:0] mask,
    output logic [NLANES-1:0] lane_full,
    output logic [NLANES-1:0] lane_empty
);

    for (genvar g = 0; g < NLANES; g++) begin : g_lane
        assign lane_full[g]  = &mask[g*LANE_W +: LANE_W];
        assign lane_empty[g] = ~|mask[g*LANE_W +: LANE_W];
    end

endmodule

// File: rtl/wsc_kind_decode.sv
module wsc_kind_decode
    import wsc_pkg::*;
#(
    parameter int NLANES = WSC_DATA_W / WSC_LANE_W,
    localparam int IDX_W = idx_width(NLANES)
) (
    input  logic              is_write,
    input  logic [NLANES-1:0] lane_full,
    input  logic [NLANES-1:0] lane_empty,
    output class_t            cls,
    output logic [IDX_W-1:0]  lane_idx
);

    logic [NLANES-1:0] used;
    logic              single;

    always_comb begin
        used     = ~lane_empty;
        single   = ($countones(used) == 1) && ((used & lane_full) == used);
        lane_idx = '0;
        for (int i = 0; i < NLANES; i++) begin
            if (used[i]) lane_idx = IDX_W'(i);
        end
        if (!is_write) begin
            cls = '{kind: KIND_LOAD, fault: 1'b0};
        end else if (&lane_full) begin
            cls = '{kind: KIND_WIDE, fault: 1'b0};
        end else if (single) begin
            cls = '{kind: KIND_NARROW, fault: 1'b0};
        end else begin
            cls = '{kind: KIND_ERR, fault: 1'b1};
        end
    end

endmodule

// File: rtl/wsc_result_reg.sv
module wsc_result_reg
    import wsc_pkg::*;
#(
    parameter int ADDR_W = WSC_ADDR_W,
    parameter int DATA_W = WSC_DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load_en,
    input  class_t            nxt_cls,
    input  logic [ADDR_W-1:0] nxt_addr,
    input  logic [DATA_W-1:0] nxt_data,
    input  logic [DATA_W-1:0] nxt_mask,
    output logic              q_valid,
    output class_t            q_cls,
    output logic [ADDR_W-1:0] q_addr,
    output logic [DATA_W-1:0] q_data,
    output logic [DATA_W-1:0] q_mask
);

    always_ff @(posedge clk) begin
        if (rst || !load_en) begin
            q_valid <= 1'b0;
            q_cls   <= '{kind: KIND_LOAD, fault: 1'b0};
            q_addr  <= '0;
            q_data  <= '0;
            q_mask  <= '0;
        end else begin
            q_valid <= 1'b1;
            q_cls   <= nxt_cls;
            q_addr  <= nxt_addr;
            q_data  <= nxt_data;
            q_mask  <= nxt_mask;
        end
    end

    // R8: an idle cycle presents nothing
    assert_idle_zero_R8: assert property (@(posedge clk) disable iff (rst)
        !q_valid |-> (q_cls.kind == KIND_LOAD && !q_cls.fault &&
                      q_addr == '0 && q_data == '0 && q_mask == '0));

    // R7: fault flag agrees with the error kind
    assert_err_flag_R7: assert property (@(posedge clk) disable iff (rst)
        q_cls.fault == (q_valid && q_cls.kind == KIND_ERR));

endmodule

// File: rtl/wide_store_classifier.sv
module wide_store_classifier
    import wsc_pkg::*;
#(
    parameter int ADDR_W = WSC_ADDR_W,
    parameter int DATA_W = WSC_DATA_W,
    parameter int LANE_W = WSC_LANE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_data,
    input  logic [DATA_W-1:0] req_mask,
    output logic              out_valid,
    output logic [1:0]        out_kind,
    output logic [ADDR_W-1:0] out_addr,
    output logic [DATA_W-1:0] out_data,
    output logic [DATA_W-1:0] out_mask,
    output logic              out_err
);

    localparam int NLANES     = DATA_W / LANE_W;
    localparam int IDX_W      = idx_width(NLANES);
    localparam int OFFS_W     = $clog2(DATA_W / 8);
    localparam int LANE_SHIFT = $clog2(LANE_W / 8);

    logic [NLANES-1:0] lane_full;
    logic [NLANES-1:0] lane_empty;
    logic [IDX_W-1:0]  lane_idx;
    class_t            cls;
    class_t            q_cls;
    logic [LANE_W-1:0] lanes [NLANES];
    logic [ADDR_W-1:0] aligned;
    logic [ADDR_W-1:0] nxt_addr;
    logic [DATA_W-1:0] nxt_data;
    logic [DATA_W-1:0] nxt_mask;

    for (genvar g = 0; g < NLANES; g++) begin : g_split
        assign lanes[g] = req_data[g*LANE_W +: LANE_W];
    end

    assign aligned = {req_addr[ADDR_W-1:OFFS_W], {OFFS_W{1'b0}}};

    wsc_lane_scan #(.DATA_W(DATA_W), .LANE_W(LANE_W)) i_scan (
        .mask       (req_mask),
        .lane_full  (lane_full),
        .lane_empty (lane_empty)
    );

    wsc_kind_decode #(.NLANES(NLANES)) i_decode (
        .is_write   (req_write),
        .lane_full  (lane_full),
        .lane_empty (lane_empty),
        .cls        (cls),
        .lane_idx   (lane_idx)
    );

    always_comb begin
        nxt_addr = aligned;
        nxt_data = req_data;
        nxt_mask = '0;
        unique case (cls.kind)
            KIND_NARROW: begin
                nxt_addr = aligned + (ADDR_W'(lane_idx) << LANE_SHIFT);
                nxt_data = DATA_W'(lanes[lane_idx]);
            end
            KIND_ERR: nxt_mask = req_mask;
            default: ;
        endcase
    end

    wsc_result_reg #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_result (
        .clk      (clk),
        .rst      (rst),
        .load_en  (req_valid),
        .nxt_cls  (cls),
        .nxt_addr (nxt_addr),
        .nxt_data (nxt_data),
        .nxt_mask (nxt_mask),
        .q_valid  (out_valid),
        .q_cls    (q_cls),
        .q_addr   (out_addr),
        .q_data   (out_data),
        .q_mask   (out_mask)
    );

    assign out_kind = q_cls.kind;
    assign out_err  = q_cls.fault;

    // R2: one result per request, one cycle later
    assert_valid_follows_R2: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> out_valid);
    assert_no_spurious_R2: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !out_valid);

    // R3 and R9: loads become kind 0 at an aligned address
    assert_load_kind_R3: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_write) |=>
            (out_kind == KIND_LOAD && out_addr[OFFS_W-1:0] == '0));

    // R4: an all-ones write mask is a wide store
    assert_wide_full_mask_R4: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_write && (&req_mask)) |=> out_kind == KIND_WIDE);

    // R5: narrow result carries nothing above its lane
    assert_narrow_upper_zero_R5: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_kind == KIND_NARROW) |->
            (out_data >> LANE_W) == '0 && out_mask == '0);

    // R6: an all-zero write mask is an error
    assert_zero_mask_err_R6: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_write && req_mask == '0) |=> out_err);

endmodule

// File: tb/test_wide_store_classifier.sv
`timescale 1ns/1ps
module test_wide_store_classifier;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         req_valid = 1'b0;
    logic         req_write = 1'b0;
    logic [31:0]  req_addr = '0;
    logic [255:0] req_data = '0;
    logic [255:0] req_mask = '0;
    logic         out_valid;
    logic [1:0]   out_kind;
    logic [31:0]  out_addr;
    logic [255:0] out_data;
    logic [255:0] out_mask;
    logic         out_err;

    int checks = 0;
    int errors = 0;

    logic         e_valid = 1'b0;
    logic [1:0]   e_kind = '0;
    logic [31:0]  e_addr = '0;
    logic [255:0] e_data = '0;
    logic [255:0] e_mask = '0;
    logic         e_err = 1'b0;
    string        e_tag = "R8";
    string        e_note = "idle";

    always #2 clk = ~clk;

    wide_store_classifier i_wide_store_classifier (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_data(req_data), .req_mask(req_mask),
        .out_valid(out_valid), .out_kind(out_kind), .out_addr(out_addr),
        .out_data(out_data), .out_mask(out_mask), .out_err(out_err)
    );

    task automatic check(string tag, string what, logic [255:0] act, logic [255:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s (%s): actual %h expected %h", tag, what, e_note, act, exp);
        end
    endtask

    task automatic compare_now();
        check("R2", "valid", 256'(out_valid), 256'(e_valid));
        check(e_tag, "kind", 256'(out_kind), 256'(e_kind));
        check(e_tag, "addr", 256'(out_addr), 256'(e_addr));
        check(e_tag, "data", out_data, e_data);
        check(e_tag, "mask", out_mask, e_mask);
        check("R7", "err", 256'(out_err), 256'(e_err));
    endtask

    // Behavioural model of the expected result
    task automatic predict(bit v, bit w, logic [31:0] a, logic [255:0] d, logic [255:0] m);
        int used = 0;
        int last = 0;
        bit all_ones = 1'b1;
        logic [31:0] base;
        base = a & ~32'd31;
        e_valid = v; e_kind = 0; e_addr = 0; e_data = 0; e_mask = 0; e_err = 0;
        if (!v) begin
            e_tag = "R8";
            return;
        end
        if (!w) begin
            e_tag = "R3"; e_addr = base; e_data = d;
            return;
        end
        for (int i = 0; i < 256; i++) if (!m[i]) all_ones = 1'b0;
        for (int l = 0; l < 8; l++) begin
            if (m[l*32 +: 32] != 32'd0) begin
                used++;
                last = l;
            end
        end
        if (all_ones) begin
            e_tag = "R4"; e_kind = 1; e_addr = base; e_data = d;
        end else if (used == 1 && m[last*32 +: 32] == 32'hffff_ffff) begin
            e_tag = "R5"; e_kind = 2; e_addr = base + 32'(4 * last);
            e_data = 256'(d[last*32 +: 32]);
        end else begin
            e_tag = "R6"; e_kind = 3; e_addr = base; e_data = d; e_mask = m; e_err = 1'b1;
        end
    endtask

    task automatic step(string note, bit v, bit w, logic [31:0] a,
                        logic [255:0] d, logic [255:0] m);
        @(negedge clk);
        compare_now();
        req_valid = v; req_write = w; req_addr = a; req_data = d; req_mask = m;
        predict(v, w, a, d, m);
        e_note = note;
    endtask

    function automatic logic [255:0] rnd256();
        logic [255:0] r;
        for (int i = 0; i < 8; i++) r[i*32 +: 32] = $urandom;
        return r;
    endfunction

    function automatic logic [255:0] lane_mask(int k);
        return 256'hffff_ffff << (32 * k);
    endfunction

    initial begin
        #(4 * 100000);
        checks++;
        errors++;
        $display("FAIL R2 watchdog: actual hung expected finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [255:0] ones;
        ones = '1;
        repeat (3) @(negedge clk);
        // R1: outputs during reset and in the first cycle after it falls
        check("R1", "valid in reset", 256'(out_valid), 256'(0));
        check("R1", "data in reset", out_data, 256'(0));
        rst = 1'b0;
        @(negedge clk);
        check("R1", "valid after reset", 256'(out_valid), 256'(0));
        check("R1", "kind after reset", 256'(out_kind), 256'(0));
        check("R1", "err after reset", 256'(out_err), 256'(0));

        step("load unaligned R9", 1, 0, 32'h0000_1234, rnd256(), '0);
        step("load ignores full mask R3", 1, 0, 32'h0000_0040, rnd256(), ones);
        step("idle", 0, 0, '0, '0, '0);
        step("wide R4", 1, 1, 32'h0000_0080, rnd256(), ones);
        step("wide unaligned R9", 1, 1, 32'h0000_00bf, rnd256(), ones);
        for (int k = 0; k < 8; k++) begin
            step("narrow lane R5", 1, 1, 32'h0000_0200 + 32'(k), rnd256(), lane_mask(k));
        end
        step("zero mask R6", 1, 1, 32'h0000_0300, rnd256(), '0);
        step("partial lane R6", 1, 1, 32'h0000_0320, rnd256(), 256'h00ff_ffff << 64);
        step("two lanes R6", 1, 1, 32'h0000_0340, rnd256(), lane_mask(1) | lane_mask(5));
        step("lane plus stray R6", 1, 1, 32'h0000_0360, rnd256(), lane_mask(2) | (256'd1 << 200));
        step("seven lanes R6", 1, 1, 32'h0000_0380, rnd256(), ~lane_mask(7));
        step("all but one bit R6", 1, 1, 32'h0000_03a0, rnd256(), ~(256'd1 << 131));
        step("idle", 0, 1, 32'h0000_0400, rnd256(), ones);
        // back-to-back mixed kinds
        step("b2b err R6", 1, 1, 32'h0000_0420, rnd256(), 256'h1);
        step("b2b narrow R5", 1, 1, 32'h0000_0440, rnd256(), lane_mask(6));
        step("b2b load R3", 1, 0, 32'h0000_0460, rnd256(), lane_mask(6));
        step("b2b wide R4", 1, 1, 32'h0000_0480, rnd256(), ones);
        step("b2b err R6", 1, 1, 32'h0000_04a0, rnd256(), lane_mask(0) | lane_mask(1));
        for (int n = 0; n < 40; n++) begin
            logic [255:0] m;
            int sel;
            sel = int'($urandom % 5);
            case (sel)
                0: m = ones;
                1: m = lane_mask(int'($urandom % 8));
                2: m = rnd256();
                3: m = lane_mask(int'($urandom % 8)) | (256'd1 << ($urandom % 256));
                default: m = '0;
            endcase
            step("random", 1'($urandom % 4 != 0), 1'($urandom % 3 != 0), $urandom, rnd256(), m);
        end
        step("idle", 0, 0, '0, '0, '0);
        step("idle", 0, 0, '0, '0, '0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule